// File: doc/BRIEF.md
# Two-Port GPIO Register Bank

This block holds the register state of a sixteen-pin general-purpose I/O expander arranged as two eight-bit ports. A serial-bus controller decodes the bus traffic and hands the block write strobes carrying a register index and a data byte. It also presents a read index and collects the matching byte one clock later. Each port has four byte registers. One samples the pins. One holds the levels to drive. One inverts selected bits of the sampled value on readback. One chooses per pin whether the pad driver is enabled.

The block drives an output-enable and an output-value line for each pin toward tri-state pad cells. It samples the pad levels through a two-stage synchroniser. Pad electrical behaviour is handled outside the block, and so is the bus protocol.

Top module: `gpio_bank`

## Requirements
- R1: On a clock edge with `rst_n` low, every direction bit becomes 1, every output bit becomes 1 and every polarity bit becomes 0. As a result, all `pin_oe` bits read 0 once reset is released.
- R2: A write with `wr_en` high stores `wr_data` into the register chosen by `wr_idx`. In the index, bits [2:1] give the kind (1 output, 2 polarity, 3 direction) and bit [0] gives the port. A later read of the same index returns the stored byte.
- R3: A pin whose direction bit is 0 has `pin_oe` set to 1 and `pin_out` equal to its output-register bit, starting from the edge that wrote either register.
- R4: A pin whose direction bit is 1 has `pin_oe` at 0 and `pin_out` at 0, whatever its output-register bit holds.
- R5: Reading kind 0 (index 0 or 1) returns the sampled pin level for that port, whatever the pin direction. A pin change made before edge k is first seen in `rd_data` after edge k+2.
- R6: Writes to index 0 or 1 change no register: every readback, `pin_oe` and `pin_out` stay as they were.
- R7: A polarity bit of 1 inverts the matching bit of an input-register readback. A polarity bit of 0 passes it unchanged.
- R8: Reading an output register returns the stored latch byte, even when the pad level differs.
- R9: `rd_data` after edge k reflects the `rd_idx` presented at edge k, so reads may be issued back to back.
- R10: A write to one port's register leaves the same register of the other port unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_idx | input | 3 | Register index of the write |
| wr_data | input | 8 | Byte to write |
| rd_idx | input | 3 | Register index to read |
| rd_data | output | 8 | Read byte, registered |
| pin_in | input | 16 | Pad levels, asynchronous |
| pin_oe | output | 16 | Per-pin driver enable |
| pin_out | output | 16 | Per-pin drive value |

## Verification
A corrupt direction or output latch shows at once on `pin_oe` and `pin_out`, in the cycle after the edge that wrote it, with no read needed. A corrupt polarity latch, or a fault in the index decode, shows only when the affected index is read. It then appears one cycle after that read. A fault in the synchroniser path shows as input readbacks that arrive a cycle early or a cycle late. The bench therefore checks the exact edge on which a pin change first appears.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the register-kind encoding of the GPIO bank.
// Assumes an index laid out as {kind[1:0], port select}.
package gpio_bank_pkg;
    localparam int PORT_W_DEF    = 8;
    localparam int NUM_PORTS_DEF = 2;
    localparam int KIND_W        = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_INPUT    = 2'd0,
        KIND_OUTPUT   = 2'd1,
        KIND_POLARITY = 2'd2,
        KIND_CONFIG   = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
// Module: two-stage synchroniser for the asynchronous pad levels.
// Assumes each bit is independent; no multi-bit coherence is promised.
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;

    // Two back-to-back flops; reset clears both stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            sync_out <= '0;
        end else begin
            stage1_q <= async_in;
            sync_out <= stage1_q;
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
// Module: the writable registers of one port (drive, polarity, direction)
// and the pad-control outputs derived from them.
// Assumes the write strobes are already decoded and are one-hot or idle.
module gpio_port_regs #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_out,
    input  logic              wr_pol,
    input  logic              wr_cfg,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] out_q,
    output logic [PORT_W-1:0] pol_q,
    output logic [PORT_W-1:0] cfg_q,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_o
);
    // Register update: reset defaults, else load on the matching strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '1;
            pol_q <= '0;
            cfg_q <= '1;
        end else begin
            if (wr_out) out_q <= wr_data;
            if (wr_pol) pol_q <= wr_data;
            if (wr_cfg) cfg_q <= wr_data;
        end
    end

    // Pad control: a cleared direction bit enables the driver; input pins drive 0.
    always_comb begin
        pad_oe = ~cfg_q;
        pad_o  = out_q & ~cfg_q;
    end

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> cfg_q == $past(wr_data)); // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_out |=> $stable(out_q)); // R2
    AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pol |=> $stable(pol_q)); // R10
endmodule

// File: rtl/gpio_read_mux.sv
`timescale 1ns/1ps
// Module: registered read path. It selects one register byte by index and
// applies polarity inversion to input-register reads only.
// Assumes out-of-range port selects read as zero.
module gpio_read_mux
    import gpio_bank_pkg::*;
#(
    parameter int PORT_W    = 8,
    parameter int NUM_PORTS = 2,
    parameter int PSEL_W    = 1,
    parameter int IDX_W     = KIND_W + PSEL_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [IDX_W-1:0]                  rd_idx,
    input  logic [NUM_PORTS-1:0][PORT_W-1:0]  in_sync,
    input  logic [NUM_PORTS-1:0][PORT_W-1:0]  out_all,
    input  logic [NUM_PORTS-1:0][PORT_W-1:0]  pol_all,
    input  logic [NUM_PORTS-1:0][PORT_W-1:0]  cfg_all,
    output logic [PORT_W-1:0]                 rd_data
);
    reg_kind_e         kind;
    logic [PSEL_W-1:0] psel;
    logic [PORT_W-1:0] sel_byte;

    // Split the index and pick the addressed byte.
    always_comb begin
        kind     = reg_kind_e'(rd_idx[IDX_W-1 -: KIND_W]);
        psel     = rd_idx[PSEL_W-1:0];
        sel_byte = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (psel == PSEL_W'(p)) begin
                case (kind)
                    KIND_INPUT:    sel_byte = in_sync[p] ^ pol_all[p];
                    KIND_OUTPUT:   sel_byte = out_all[p];
                    KIND_POLARITY: sel_byte = pol_all[p];
                    default:       sel_byte = cfg_all[p];
                endcase
            end
        end
    end

    // Read register: one cycle from index to data.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= sel_byte;
    end

    AST_OUT_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IDX_W'({KIND_OUTPUT, 1'b0})) |=> rd_data == $past(out_all[0])); // R8
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
// Module: top of the GPIO register bank. It decodes write strobes per port,
// instantiates the port registers, the pad synchroniser and the read path.
// Assumes one write per cycle from the bus front end.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PORT_W    = PORT_W_DEF,
    parameter int NUM_PORTS = NUM_PORTS_DEF,
    parameter int PSEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    parameter int IDX_W     = KIND_W + PSEL_W,
    parameter int PIN_W     = PORT_W * NUM_PORTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PORT_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_oe,
    output logic [PIN_W-1:0]  pin_out
);
    logic [PIN_W-1:0]                  pin_sync;
    logic [NUM_PORTS-1:0][PORT_W-1:0]  in_all;
    logic [NUM_PORTS-1:0][PORT_W-1:0]  out_all;
    logic [NUM_PORTS-1:0][PORT_W-1:0]  pol_all;
    logic [NUM_PORTS-1:0][PORT_W-1:0]  cfg_all;
    reg_kind_e                         wr_kind;
    logic [PSEL_W-1:0]                 wr_psel;

    // Split the write index into kind and port select.
    always_comb begin
        wr_kind = reg_kind_e'(wr_idx[IDX_W-1 -: KIND_W]);
        wr_psel = wr_idx[PSEL_W-1:0];
    end

    gpio_sync #(.W(PIN_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        // Port hit: strobe active and the select matches this port.
        always_comb hit = wr_en && (wr_psel == PSEL_W'(p));

        assign in_all[p] = pin_sync[p*PORT_W +: PORT_W];

        gpio_port_regs #(.PORT_W(PORT_W)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_out  (hit && wr_kind == KIND_OUTPUT),
            .wr_pol  (hit && wr_kind == KIND_POLARITY),
            .wr_cfg  (hit && wr_kind == KIND_CONFIG),
            .wr_data (wr_data),
            .out_q   (out_all[p]),
            .pol_q   (pol_all[p]),
            .cfg_q   (cfg_all[p]),
            .pad_oe  (pin_oe[p*PORT_W +: PORT_W]),
            .pad_o   (pin_out[p*PORT_W +: PORT_W])
        );
    end

    gpio_read_mux #(
        .PORT_W    (PORT_W),
        .NUM_PORTS (NUM_PORTS),
        .PSEL_W    (PSEL_W),
        .IDX_W     (IDX_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .in_sync (in_all),
        .out_all (out_all),
        .pol_all (pol_all),
        .cfg_all (cfg_all),
        .rd_data (rd_data)
    );

    AST_RESET_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pin_oe == '0); // R1
    AST_INPUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == KIND_INPUT) |=> ($stable(out_all) && $stable(pol_all) && $stable(cfg_all))); // R6
    AST_INPUT_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0); // R4
endmodule

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks push expected bytes; a monitor pops and compares.
module sim_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_idx = '0;
    logic [7:0]  rd_data;
    logic [15:0] pin_in = 16'hA5C3;
    logic [15:0] pin_oe;
    logic [15:0] pin_out;

    int vectors = 0;
    int errors  = 0;

    logic [7:0] m_out [2];
    logic [7:0] m_pol [2];
    logic [7:0] m_cfg [2];

    logic [7:0] exp_q [$];
    string      req_q [$];
    logic       rd_req = 1'b0;
    logic       mon_arm = 1'b0;

    always #5 clk = ~clk;

    gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    function automatic logic [7:0] model_read(input logic [2:0] idx);
        int p = idx[0];
        case (idx[2:1])
            2'd0:    return pin_in[p*8 +: 8] ^ m_pol[p];
            2'd1:    return m_out[p];
            2'd2:    return m_pol[p];
            default: return m_cfg[p];
        endcase
    endfunction

    function automatic logic [15:0] model_oe();
        return ~{m_cfg[1], m_cfg[0]};
    endfunction

    function automatic logic [15:0] model_pout();
        return {m_out[1], m_out[0]} & ~{m_cfg[1], m_cfg[0]};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        vectors++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (idx[2:1])
            2'd1: m_out[idx[0]] = d;
            2'd2: m_pol[idx[0]] = d;
            2'd3: m_cfg[idx[0]] = d;
            default: ;
        endcase
    endtask

    // Driver: present an index and queue the byte the requirements predict.
    task automatic rd(input logic [2:0] idx, input string req);
        @(negedge clk);
        rd_idx = idx; rd_req = 1'b1;
        exp_q.push_back(model_read(idx));
        req_q.push_back(req);
    endtask

    task automatic rd_done();
        @(negedge clk);
        rd_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: the byte captured at the edge after a request is compared here.
    always @(posedge clk) mon_arm <= rd_req;
    always @(negedge clk) begin
        if (mon_arm && exp_q.size() > 0) begin
            logic [7:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(r, {8'h00, rd_data}, {8'h00, e});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        m_out[0] = 8'hFF; m_out[1] = 8'hFF;
        m_pol[0] = 8'h00; m_pol[1] = 8'h00;
        m_cfg[0] = 8'hFF; m_cfg[1] = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: defaults after reset
        check("R1 oe", pin_oe, 16'h0000);
        check("R4 out", pin_out, 16'h0000);
        for (int i = 1; i < 8; i++) rd(3'(i), "R1");
        rd(3'd0, "R5"); rd(3'd1, "R5");
        rd_done();

        // R3/R2: low nibble of port 0 becomes output
        wr(3'd6, 8'hF0);
        wr(3'd2, 8'h3C);
        check("R3 oe", pin_oe, model_oe());
        check("R3 out", pin_out, model_pout());
        check("R3 value", pin_out, 16'h000C);
        rd(3'd2, "R2"); rd(3'd6, "R2");
        // R8 latch read while pad shows 0xC3; R5 input reflects pad on output pins
        rd(3'd0, "R5");
        rd_done();
        wr(3'd2, 8'h35);
        rd(3'd2, "R8");
        rd_done();

        // R10: write port 1 registers, port 0 unchanged
        wr(3'd3, 8'h12);
        wr(3'd5, 8'h0F);
        rd(3'd2, "R10"); rd(3'd4, "R10"); rd(3'd3, "R2"); rd(3'd5, "R2");
        rd_done();

        // R7: polarity on input reads
        wr(3'd4, 8'hFF);
        set_pins(16'h81C3);
        rd(3'd0, "R7"); rd(3'd1, "R7"); rd(3'd4, "R7");
        rd_done();

        // R6: writes to index 0 and 1 are ignored
        wr(3'd0, 8'h55);
        wr(3'd1, 8'hAA);
        check("R6 oe", pin_oe, model_oe());
        check("R6 out", pin_out, model_pout());
        for (int i = 0; i < 8; i++) rd(3'(i), "R6");
        rd_done();

        // R4: output bits have no effect on input pins
        wr(3'd7, 8'hFF);
        wr(3'd3, 8'h00);
        check("R4 oe", pin_oe[15:8], 8'h00);
        check("R4 out", pin_out[15:8], 8'h00);
        wr(3'd3, 8'hFF);
        check("R4 out", pin_out[15:8], 8'h00);
        wr(3'd7, 8'h00);
        check("R3 out", pin_out[15:8], 8'hFF);
        check("R3 oe", pin_oe[15:8], 8'hFF);

        // R5: latency of a pad change into rd_data (index 1 held, pol1=0x0F)
        @(negedge clk);
        rd_idx = 3'd1;
        @(negedge clk);
        pin_in[15:8] = 8'h5A;
        @(negedge clk);
        check("R5 edge1", {8'h00, rd_data}, {8'h00, 8'h81 ^ 8'h0F});
        @(negedge clk);
        check("R5 edge2", {8'h00, rd_data}, {8'h00, 8'h81 ^ 8'h0F});
        @(negedge clk);
        check("R5 edge3", {8'h00, rd_data}, {8'h00, 8'h5A ^ 8'h0F});

        // R9: back-to-back reads of differing indices
        rd(3'd7, "R9"); rd(3'd2, "R9"); rd(3'd1, "R9"); rd(3'd6, "R9");
        rd_done();

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R9 drain", 16'(exp_q.size()), 16'h0000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule